// File: doc/BRIEF.md
# CPU Buffer Data Port Handshake

This block lets a processor move single bytes to or from a buffer memory through one data register and an address counter that advances by itself. Two status flags pace the processor. In read mode the block prefetches the byte at the current address into the data register whenever that register is empty and raises `rd_ready`. A processor read of the register drops the flag, advances the address and starts the next fetch. In write mode `wr_ready` starts at 1. A processor write fills the register and drops the flag. Once the memory has stored the byte, the flag returns to 1 and the address advances.

The memory side is a valid/ready request channel followed by a one-beat response. Once `mem_req_valid` is high, it stays high and `mem_req_addr`, `mem_req_we` and `mem_req_wdata` stay unchanged until `mem_req_ready` is seen high at a clock edge. The request is then accepted. The memory applies back-pressure only by holding `mem_req_ready` low. `mem_rsp_valid` is a single-cycle pulse that completes the accepted request, whether it was a read or a write. The block always accepts it and never stalls it. A response that arrives while no request is outstanding is ignored. There is no transfer counter: the port runs until the enable bit is cleared.

Top module: `cpu_bufport`

## Requirements
- R1: After reset, `rd_ready`, `wr_ready` and `mem_req_valid` are 0, `addr_out` is 0 and `cpu_rdata` is 0.
- R2: With `enable` set and `dir_wr` = 0 (read mode), the block requests a read at `addr_out`. When the response arrives, its data appears on `cpu_rdata` and `rd_ready` becomes 1.
- R3: A `cpu_rd` pulse while `rd_ready` = 1 gives `rd_ready` = 0 and `addr_out` + 1 in the next cycle, and the block then fetches the byte at the new address.
- R4: A `cpu_rd` pulse while `rd_ready` = 0 leaves `cpu_rdata` and `addr_out` unchanged and starts no extra fetch.
- R5: With `enable` set and `dir_wr` = 1 (write mode), `wr_ready` becomes 1. A `cpu_wr` pulse while `wr_ready` = 1 clears it and issues a write request with `mem_req_we` = 1, carrying `cpu_wdata` at `addr_out`.
- R6: When the response to a write arrives, `wr_ready` returns to 1 and `addr_out` advances by 1, and the byte is stored at the old address.
- R7: A `cpu_wr` pulse while `wr_ready` = 0 is ignored: the byte already in flight is the one stored.
- R8: While `enable` is 0, both ready flags and `mem_req_valid` are 0 from the next cycle on, and any pending fetch or write is dropped.
- R9: `addr_load` loads `addr_load_val` into the counter, and it takes priority over an increment in the same cycle. `addr_out` always shows the counter. The counter wraps from all ones to 0.
- R10: While `mem_req_valid` = 1 and `mem_req_ready` = 0, the request holds in the next cycle with unchanged address, data and direction.
- R11: `dir_wr` is sampled only when operation starts, so changing it while `enable` stays 1 does not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the port; 0 aborts and idles it |
| dir_wr | input | 1 | 0 = read from memory, 1 = write to memory |
| addr_load | input | 1 | Load the address counter |
| addr_load_val | input | AW | Value to load |
| addr_out | output | AW | Current address counter |
| cpu_rd | input | 1 | Processor read strobe of the data register |
| cpu_wr | input | 1 | Processor write strobe of the data register |
| cpu_wdata | input | DW | Byte written by the processor |
| cpu_rdata | output | DW | Data register contents |
| rd_ready | output | 1 | A fetched byte waits in the data register |
| wr_ready | output | 1 | The data register may be written |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Request write data |
| mem_rsp_valid | input | 1 | Request completed (one-cycle pulse) |
| mem_rsp_data | input | DW | Read data with the response |

## Verification
The hardest cases to reach from the ports are the ones where a processor strobe arrives while a request is still waiting on back-pressure or on its response. These are a read while the prefetch is in flight and a second write on top of an uncommitted one. The bench gets there by holding `mem_req_ready` low at random, drawing a random response delay, and firing the strobes directly after the one that started the transaction. Disabling while a request is outstanding is also steered on purpose, followed by a check that the flags and the request drop.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FREQ   = 3'd1,
    ST_FWAIT  = 3'd2,
    ST_FULL   = 3'd3,
    ST_WEMPTY = 3'd4,
    ST_WREQ   = 3'd5,
    ST_WWAIT  = 3'd6
  } port_state_t;
endpackage

// File: rtl/cbp_addr_ctr.sv
module cbp_addr_ctr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (inc)  addr <= addr + ONE;
  end
endmodule

// File: rtl/cbp_data_reg.sv
module cbp_data_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_rsp,
  input  logic [DW-1:0] rsp_data,
  input  logic          cap_cpu,
  input  logic [DW-1:0] cpu_data,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (cap_rsp) q <= rsp_data;
    else if (cap_cpu) q <= cpu_data;
  end
endmodule

// File: rtl/cbp_ctrl.sv
module cbp_ctrl
  import cbp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        dir_wr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic        req_ready,
  input  logic        rsp_valid,
  output port_state_t st,
  output logic        inc,
  output logic        cap_rsp,
  output logic        cap_cpu
);
  port_state_t nx;

  always_comb begin
    nx      = st;
    inc     = 1'b0;
    cap_rsp = 1'b0;
    cap_cpu = 1'b0;
    if (!enable) begin
      nx = ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE:   nx = dir_wr ? ST_WEMPTY : ST_FREQ;
        ST_FREQ:   if (req_ready) nx = ST_FWAIT;
        ST_FWAIT:  if (rsp_valid) begin
                     nx      = ST_FULL;
                     cap_rsp = 1'b1;
                   end
        ST_FULL:   if (cpu_rd) begin
                     nx  = ST_FREQ;
                     inc = 1'b1;
                   end
        ST_WEMPTY: if (cpu_wr) begin
                     nx      = ST_WREQ;
                     cap_cpu = 1'b1;
                   end
        ST_WREQ:   if (req_ready) nx = ST_WWAIT;
        ST_WWAIT:  if (rsp_valid) begin
                     nx  = ST_WEMPTY;
                     inc = 1'b1;
                   end
        default:   nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nx;
  end
endmodule

// File: rtl/cpu_bufport.sv
module cpu_bufport
  import cbp_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          dir_wr,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_load_val,
  output logic [AW-1:0] addr_out,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          rd_ready,
  output logic          wr_ready,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  port_state_t st;
  logic        inc, cap_rsp, cap_cpu;
  logic [DW-1:0] dreg;

  cbp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dir_wr(dir_wr),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .req_ready(mem_req_ready),
    .rsp_valid(mem_rsp_valid), .st(st), .inc(inc),
    .cap_rsp(cap_rsp), .cap_cpu(cap_cpu)
  );

  cbp_addr_ctr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .load_val(addr_load_val),
    .inc(inc), .addr(addr_out)
  );

  cbp_data_reg #(.DW(DW)) u_data (
    .clk(clk), .rst_n(rst_n), .cap_rsp(cap_rsp), .rsp_data(mem_rsp_data),
    .cap_cpu(cap_cpu), .cpu_data(cpu_wdata), .q(dreg)
  );

  assign cpu_rdata     = dreg;
  assign rd_ready      = (st == ST_FULL);
  assign wr_ready      = (st == ST_WEMPTY);
  assign mem_req_valid = (st == ST_FREQ) || (st == ST_WREQ);
  assign mem_req_we    = (st == ST_WREQ);
  assign mem_req_addr  = addr_out;
  assign mem_req_wdata = dreg;
endmodule

// File: rtl/cpu_bufport_chk.sv
module cpu_bufport_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          addr_load,
  input logic          cpu_rd,
  input logic          rd_ready,
  input logic          wr_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic [DW-1:0] mem_req_wdata,
  input logic          mem_rsp_valid,
  input logic [AW-1:0] addr_out,
  input logic [DW-1:0] cpu_rdata
);
  // R8: disabled port idles next cycle
  assert_disable_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!rd_ready && !wr_ready && !mem_req_valid));

  // R10: request held under back-pressure
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && enable) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

  // R4: read strobe without a ready byte changes nothing
  assert_stale_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !rd_ready && !mem_rsp_valid && !addr_load) |=>
      ($stable(cpu_rdata) && $stable(addr_out)));

  // R9: address moves only on a load, a read strobe or a response
  assert_addr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_load && !cpu_rd && !mem_rsp_valid) |=> $stable(addr_out));

  // R3: a taken read clears the flag and requests again
  assert_read_rearm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rd_ready && cpu_rd) |=> (!rd_ready && mem_req_valid && !mem_req_we));

  // R5: flags are never both set
  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ready && wr_ready));
endmodule

bind cpu_bufport cpu_bufport_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .addr_load(addr_load),
  .cpu_rd(cpu_rd), .rd_ready(rd_ready), .wr_ready(wr_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
  .addr_out(addr_out), .cpu_rdata(cpu_rdata)
);

// File: tb/cpu_bufport_tb_top.sv
`timescale 1ns/1ps
module cpu_bufport_tb_top;
  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          enable = 0, dir_wr = 0, addr_load = 0, cpu_rd = 0, cpu_wr = 0;
  logic [AW-1:0] addr_load_val = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [AW-1:0] addr_out, mem_req_addr;
  logic [DW-1:0] cpu_rdata, mem_req_wdata;
  logic          rd_ready, wr_ready, mem_req_valid, mem_req_we, mem_req_ready;
  logic          mem_rsp_valid = 0;
  logic [DW-1:0] mem_rsp_data = '0;

  cpu_bufport #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dir_wr(dir_wr),
    .addr_load(addr_load), .addr_load_val(addr_load_val), .addr_out(addr_out),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .rd_ready(rd_ready), .wr_ready(wr_ready), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // memory model
  logic [DW-1:0] mem [1<<AW];
  logic          busy = 0, rdy_rand = 1, always_ready = 0;
  int            cnt = 0;
  logic [AW-1:0] raddr = '0;
  int            accepts = 0;
  assign mem_req_ready = !busy && (rdy_rand || always_ready);

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    rdy_rand <= ($urandom % 3) != 0;
    if (busy) begin
      if (cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[raddr];
        busy <= 1'b0;
      end else cnt <= cnt - 1;
    end else if (mem_req_valid && mem_req_ready) begin
      busy    <= 1'b1;
      cnt     <= $urandom % 3;
      raddr   <= mem_req_addr;
      accepts <= accepts + 1;
      if (mem_req_we) mem[mem_req_addr] <= mem_req_wdata;
    end
  end

  int n_checks = 0, n_fail = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic wait_flag(input bit want_rd, output bit ok);
    ok = 0;
    for (int i = 0; i < 60; i++) begin
      if (want_rd ? rd_ready : wr_ready) begin ok = 1; break; end
      tick();
    end
  endtask

  task automatic load_addr(input logic [AW-1:0] a);
    addr_load = 1; addr_load_val = a; tick(); addr_load = 0;
  endtask

  task automatic pulse_rd(); cpu_rd = 1; tick(); cpu_rd = 0; endtask
  task automatic pulse_wr(input logic [DW-1:0] d); cpu_wr = 1; cpu_wdata = d; tick(); cpu_wr = 0; endtask

  task automatic quiesce();
    enable = 0; tick(); tick(); tick(); tick(); tick();
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    bit ok;
    logic [AW-1:0] a;
    logic [DW-1:0] d, v;
    int acc0;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < (1 << AW); i++) mem[i] = DW'($urandom);
    tick(); tick();
    chk(!rd_ready && !wr_ready && !mem_req_valid, "R1 flags/req in reset", {rd_ready, wr_ready, mem_req_valid}, 0);
    rst_n = 1; tick();
    chk(addr_out == 0, "R1 addr after reset", addr_out, 0);
    chk(cpu_rdata == 0, "R1 rdata after reset", cpu_rdata, 0);

    // R9 load, readback, wrap
    load_addr(8'hff);
    chk(addr_out == 8'hff, "R9 load readback", addr_out, 8'hff);

    // R2 read mode at wrap boundary
    dir_wr = 0; enable = 1; tick();
    wait_flag(1, ok);
    chk(ok && cpu_rdata == mem[8'hff], "R2 first fetch", cpu_rdata, mem[8'hff]);
    pulse_rd();
    chk(!rd_ready && addr_out == 0, "R9 wrap on read R3", addr_out, 0);
    // R4 stale read while fetch pending
    v = cpu_rdata;
    acc0 = accepts;
    pulse_rd();
    wait_flag(1, ok);
    chk(addr_out == 0, "R4 stale read no increment", addr_out, 0);
    chk(ok && cpu_rdata == mem[0], "R4 fetch after stale read", cpu_rdata, mem[0]);
    chk(accepts - acc0 == 1, "R4 no extra fetch", accepts - acc0, 1);
    // R11 direction change ignored
    dir_wr = 1; tick(); tick();
    chk(rd_ready && !wr_ready, "R11 mode kept", {rd_ready, wr_ready}, 2);
    dir_wr = 0;

    // R9 load priority over increment
    addr_load = 1; addr_load_val = 8'h40; cpu_rd = 1; tick(); addr_load = 0; cpu_rd = 0;
    chk(addr_out == 8'h40, "R9 load beats increment", addr_out, 8'h40);
    wait_flag(1, ok);
    chk(ok && cpu_rdata == mem[8'h40], "R3 fetch at loaded addr", cpu_rdata, mem[8'h40]);

    // random reads
    for (int k = 0; k < 60; k++) begin
      wait_flag(1, ok);
      a = addr_out;
      chk(ok && cpu_rdata == mem[a], "R2 random fetch", cpu_rdata, mem[a]);
      pulse_rd();
      chk(!rd_ready && addr_out == nxt(a), "R3 read advances", addr_out, nxt(a));
      if ($urandom % 2) begin
        v = cpu_rdata;
        pulse_rd();
        chk(addr_out == nxt(a), "R4 random stale read", addr_out, nxt(a));
      end
    end

    // R8 abort during pending fetch
    wait_flag(1, ok);
    pulse_rd();
    enable = 0; tick();
    chk(!rd_ready && !wr_ready && !mem_req_valid, "R8 abort clears", {rd_ready, wr_ready, mem_req_valid}, 0);
    quiesce();

    // write mode
    load_addr(8'h80);
    dir_wr = 1; enable = 1; tick();
    chk(wr_ready, "R5 write ready after enable", wr_ready, 1);
    dir_wr = 0; // R11
    for (int k = 0; k < 60; k++) begin
      wait_flag(0, ok);
      chk(ok, "R6 write ready returns", wr_ready, 1);
      a = addr_out;
      d = DW'($urandom);
      pulse_wr(d);
      chk(!wr_ready, "R5 write clears ready", wr_ready, 0);
      if (k % 3 == 0) pulse_wr(~d);   // R7
      wait_flag(0, ok);
      chk(ok && addr_out == nxt(a), "R6 write advances", addr_out, nxt(a));
      chk(mem[a] == d, (k % 3 == 0) ? "R7 busy write ignored" : "R6 byte stored", mem[a], d);
    end
    chk(rd_ready == 0, "R11 write mode kept", rd_ready, 0);

    // R10 back-pressure directed
    wait_flag(0, ok);
    always_ready = 0;
    pulse_wr(8'h5a);
    for (int k = 0; k < 8; k++) begin
      if (mem_req_valid) chk(mem_req_we && mem_req_wdata == 8'h5a, "R10 request held", mem_req_wdata, 8'h5a);
      tick();
    end

    // R8 abort in write
    wait_flag(0, ok);
    enable = 0; tick();
    chk(!wr_ready && !mem_req_valid, "R8 write abort", {wr_ready, mem_req_valid}, 0);
    quiesce();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule